// File: doc/BRIEF.md
# Virtual Counter Read Gate

This block answers a 64-bit read of a virtual system counter. Each request carries the privilege level of the reader (0 to 3) and the current state of the access controls: whether a hypervisor level is implemented and enabled, the register width each of levels 1 and 2 runs in, whether level 0 runs under a host kernel, three counter enable/trap bits and the trap-general bit. The block resolves these controls through a fixed priority tree. It then either returns the counter value or reports one refusal outcome, which carries a target level and a syndrome code.

When the read is allowed, the value is the free-running physical count, with the virtual offset taken away whenever the configuration calls for it. It is delivered as a low word and a high word. The physical count and the offset are captured in the request cycle. Every result appears on registered outputs together with a single-cycle valid pulse.

Top module: `vcnt_read_gate`

## Requirements
- R1: While reset is high and in the cycle after it is released, `rsp_valid` is 0 and every response output is 0.
- R2: A request in cycle N gives `rsp_valid`=1 in cycle N+1 only. The response uses the count and offset sampled in cycle N, and back-to-back requests each use their own sample.
- R3: An allowed read that applies the offset returns count minus offset modulo 2^64, with no saturation. `rsp_lo` carries bits 31:0 and `rsp_hi` carries bits 63:32, so a borrow out of the low word reaches the high word.
- R4: At level 1, a hypervisor that is enabled and 64-bit with its level-1 trap bit set gives kind 1, target 2, syndrome 0x04. Otherwise the read is allowed and applies the offset exactly when a hypervisor is implemented.
- R5: At level 0, with a 64-bit level 1, no host mode and the user enable at 0, the outcome is kind 1 with syndrome 0x04. The target is 2 when the hypervisor is enabled, 64-bit, with trap-general set, and 1 otherwise.
- R6: At level 0, with a 32-bit level 1 and the user enable at 0, the first match wins. An enabled 64-bit hypervisor with trap-general set gives kind 1, target 2, syndrome 0x04. An enabled 32-bit hypervisor with trap-general set gives kind 2, target 2, syndrome 0x00. Any other case gives kind 3, target 0, syndrome 0x00.
- R7: At level 0 in host mode, a hypervisor user enable at 0 gives kind 1, target 2, syndrome 0x04. Outside host mode, an enabled 64-bit hypervisor with its level-1 trap bit set gives the same outcome. With the hypervisor present but disabled, that trap bit has no effect.
- R8: With no hypervisor implemented, an allowed read at level 0 or 1 returns the raw physical count.
- R9: Levels 2 and 3 are never refused. Level 2 always applies the offset. Level 3 applies it only when a hypervisor is implemented.
- R10: At level 0 with an enabled 64-bit hypervisor in host mode, an allowed read returns the raw count.
- R11: The outcome code is 0 for data, 1 for a system-register trap, 2 for a 32-bit hypervisor trap and 3 for undefined. With code 0, target and syndrome are 0. With any other code, `rsp_lo` and `rsp_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| priv_lvl | input | 2 | Privilege level of the reader |
| hyp_present | input | 1 | Hypervisor level implemented |
| hyp_enabled | input | 1 | Hypervisor level enabled |
| lvl1_is32 | input | 1 | Level 1 uses 32-bit registers |
| hyp_is32 | input | 1 | Hypervisor uses 32-bit registers |
| host_mode | input | 1 | Level 0 runs under a host kernel |
| usr_cnt_en | input | 1 | Level-1 control: user counter enable |
| hyp_usr_cnt_en | input | 1 | Hypervisor control: user counter enable in host mode |
| lvl1_cnt_trap | input | 1 | Hypervisor control: trap level 0/1 counter reads |
| trap_general | input | 1 | Route level-0 refusals to the hypervisor |
| phys_count | input | 64 | Free-running physical count |
| virt_offset | input | 64 | Virtual offset |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_lo | output | 32 | Result bits 31:0 |
| rsp_hi | output | 32 | Result bits 63:32 |
| rsp_kind | output | 2 | Outcome code |
| rsp_target | output | 2 | Target level of a refusal |
| rsp_syndrome | output | 8 | Syndrome code of a refusal |

## Verification
Every result is due exactly one clock after its request: one register stage sits between the request inputs and all six response outputs. The bench drives each request on a falling edge and drops the strobe on the next falling edge. It reads the outputs at that second falling edge, when the single rising edge between the two has just loaded them. The table walk applies each control combination this way. The directed back-to-back case then checks that two consecutive responses carry their own sampled counts. A further idle cycle is checked to confirm that the strobe lasts only one cycle.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;

    localparam int CNT_W  = 64;
    localparam int HALF_W = CNT_W / 2;
    localparam int LVL_W  = 2;
    localparam int SYN_W  = 8;

    localparam logic [LVL_W-1:0] LVL_OS  = 2'd1;
    localparam logic [LVL_W-1:0] LVL_HYP = 2'd2;

    localparam logic [SYN_W-1:0] SYN_SYSREG = 8'h04;
    localparam logic [SYN_W-1:0] SYN_HYPREG = 8'h00;

    typedef enum logic [1:0] {
        OUT_DATA     = 2'd0,
        OUT_SYS_TRAP = 2'd1,
        OUT_HYP_TRAP = 2'd2,
        OUT_UNDEF    = 2'd3
    } outcome_e;

    typedef struct packed {
        logic hyp_present;
        logic hyp_enabled;
        logic lvl1_is32;
        logic hyp_is32;
        logic host_mode;
        logic usr_cnt_en;
        logic hyp_usr_cnt_en;
        logic lvl1_cnt_trap;
        logic trap_general;
    } access_cfg_t;

    typedef struct packed {
        outcome_e           kind;
        logic [LVL_W-1:0]   target;
        logic [SYN_W-1:0]   syndrome;
        logic               use_offset;
    } verdict_t;

    function automatic verdict_t sys_trap(input logic [LVL_W-1:0] tgt);
        verdict_t v;
        v.kind       = OUT_SYS_TRAP;
        v.target     = tgt;
        v.syndrome   = SYN_SYSREG;
        v.use_offset = 1'b0;
        return v;
    endfunction

    function automatic verdict_t decide(input logic [LVL_W-1:0] lvl,
                                        input access_cfg_t c);
        verdict_t v;
        logic     hyp64;
        logic     hyp32;
        hyp64        = c.hyp_enabled && !c.hyp_is32;
        hyp32        = c.hyp_enabled &&  c.hyp_is32;
        v.kind       = OUT_DATA;
        v.target     = '0;
        v.syndrome   = '0;
        v.use_offset = 1'b0;
        case (lvl)
            2'd0: begin
                if (!c.lvl1_is32 && !c.host_mode && !c.usr_cnt_en) begin
                    v = sys_trap((hyp64 && c.trap_general) ? LVL_HYP : LVL_OS);
                end else if (c.lvl1_is32 && !c.usr_cnt_en) begin
                    if (hyp64 && c.trap_general) begin
                        v = sys_trap(LVL_HYP);
                    end else if (hyp32 && c.trap_general) begin
                        v.kind     = OUT_HYP_TRAP;
                        v.target   = LVL_HYP;
                        v.syndrome = SYN_HYPREG;
                    end else begin
                        v.kind = OUT_UNDEF;
                    end
                end else if (c.host_mode && !c.hyp_usr_cnt_en) begin
                    v = sys_trap(LVL_HYP);
                end else if (hyp64 && !c.host_mode && c.lvl1_cnt_trap) begin
                    v = sys_trap(LVL_HYP);
                end else begin
                    v.use_offset = c.hyp_present &&
                                   (c.hyp_is32 || !c.hyp_enabled || !c.host_mode);
                end
            end
            2'd1: begin
                if (hyp64 && c.lvl1_cnt_trap) begin
                    v = sys_trap(LVL_HYP);
                end else begin
                    v.use_offset = c.hyp_present;
                end
            end
            2'd2:    v.use_offset = 1'b1;
            default: v.use_offset = c.hyp_present;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vcnt_trap_decide.sv
module vcnt_trap_decide
    import vcnt_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  access_cfg_t      cfg,
    output verdict_t         verdict
);
    always_comb verdict = decide(lvl, cfg);
endmodule

// File: rtl/vcnt_offset_sub.sv
module vcnt_offset_sub #(
    parameter int W = 64
) (
    input  logic [W-1:0]   count,
    input  logic [W-1:0]   offset,
    input  logic           apply,
    output logic [W/2-1:0] lo,
    output logic [W/2-1:0] hi
);
    localparam int H = W / 2;
    logic [W-1:0] diff;

    always_comb begin
        diff = apply ? (count - offset) : count;
        lo   = diff[H-1:0];
        hi   = diff[W-1:H];
    end
endmodule

// File: rtl/vcnt_read_gate.sv
module vcnt_read_gate
    import vcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        priv_lvl,
    input  logic              hyp_present,
    input  logic              hyp_enabled,
    input  logic              lvl1_is32,
    input  logic              hyp_is32,
    input  logic              host_mode,
    input  logic              usr_cnt_en,
    input  logic              hyp_usr_cnt_en,
    input  logic              lvl1_cnt_trap,
    input  logic              trap_general,
    input  logic [63:0]       phys_count,
    input  logic [63:0]       virt_offset,
    output logic              rsp_valid,
    output logic [31:0]       rsp_lo,
    output logic [31:0]       rsp_hi,
    output logic [1:0]        rsp_kind,
    output logic [1:0]        rsp_target,
    output logic [7:0]        rsp_syndrome
);
    access_cfg_t       cfg;
    verdict_t          verdict;
    logic [HALF_W-1:0] res_lo;
    logic [HALF_W-1:0] res_hi;
    logic              is_data;

    always_comb begin
        cfg.hyp_present    = hyp_present;
        cfg.hyp_enabled    = hyp_enabled;
        cfg.lvl1_is32      = lvl1_is32;
        cfg.hyp_is32       = hyp_is32;
        cfg.host_mode      = host_mode;
        cfg.usr_cnt_en     = usr_cnt_en;
        cfg.hyp_usr_cnt_en = hyp_usr_cnt_en;
        cfg.lvl1_cnt_trap  = lvl1_cnt_trap;
        cfg.trap_general   = trap_general;
    end

    vcnt_trap_decide u_decide (
        .lvl     (priv_lvl),
        .cfg     (cfg),
        .verdict (verdict)
    );

    vcnt_offset_sub #(.W(CNT_W)) u_sub (
        .count  (phys_count),
        .offset (virt_offset),
        .apply  (verdict.use_offset),
        .lo     (res_lo),
        .hi     (res_hi)
    );

    assign is_data = (verdict.kind == OUT_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_lo       <= '0;
            rsp_hi       <= '0;
            rsp_kind     <= OUT_DATA;
            rsp_target   <= '0;
            rsp_syndrome <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_lo       <= is_data ? res_lo : '0;
                rsp_hi       <= is_data ? res_hi : '0;
                rsp_kind     <= verdict.kind;
                rsp_target   <= verdict.target;
                rsp_syndrome <= verdict.syndrome;
            end
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R9
    upper_lvl_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(priv_lvl[1])) |-> (rsp_kind == OUT_DATA));

    // R3
    lvl2_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(priv_lvl) == 2'd2)
        |-> ({rsp_hi, rsp_lo} == $past(phys_count) - $past(virt_offset)));

    // R11
    trap_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind != OUT_DATA) |-> (rsp_lo == '0 && rsp_hi == '0));

    // R11
    data_zero_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == OUT_DATA) |-> (rsp_target == '0 && rsp_syndrome == '0));

    // R5
    sys_trap_code_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == OUT_SYS_TRAP)
        |-> (rsp_syndrome == SYN_SYSREG && rsp_target != 2'd0 && rsp_target != 2'd3));

endmodule

// File: tb/vcnt_read_gate_tb.sv
module vcnt_read_gate_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  priv_lvl;
    logic        hyp_present, hyp_enabled, lvl1_is32, hyp_is32, host_mode;
    logic        usr_cnt_en, hyp_usr_cnt_en, lvl1_cnt_trap, trap_general;
    logic [63:0] phys_count, virt_offset;
    logic        rsp_valid;
    logic [31:0] rsp_lo, rsp_hi;
    logic [1:0]  rsp_kind, rsp_target;
    logic [7:0]  rsp_syndrome;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vcnt_read_gate u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .priv_lvl(priv_lvl),
        .hyp_present(hyp_present), .hyp_enabled(hyp_enabled),
        .lvl1_is32(lvl1_is32), .hyp_is32(hyp_is32), .host_mode(host_mode),
        .usr_cnt_en(usr_cnt_en), .hyp_usr_cnt_en(hyp_usr_cnt_en),
        .lvl1_cnt_trap(lvl1_cnt_trap), .trap_general(trap_general),
        .phys_count(phys_count), .virt_offset(virt_offset),
        .rsp_valid(rsp_valid), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi),
        .rsp_kind(rsp_kind), .rsp_target(rsp_target), .rsp_syndrome(rsp_syndrome)
    );

    // entry: {level, cfg[8:0], kind, target, syndrome, apply_offset}
    // cfg bits: present, enabled, l1_32, hyp_32, host, usr_en, hyp_usr_en, l1_trap, tgen
    localparam int NVEC = 17;
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 9'b110001100, 2'd0, 2'd0, 8'h00, 1'b1},
        {2'd0, 9'b110000101, 2'd1, 2'd2, 8'h04, 1'b0},
        {2'd0, 9'b110000100, 2'd1, 2'd1, 8'h04, 1'b0},
        {2'd0, 9'b111000101, 2'd1, 2'd2, 8'h04, 1'b0},
        {2'd0, 9'b111100101, 2'd2, 2'd2, 8'h00, 1'b0},
        {2'd0, 9'b111100100, 2'd3, 2'd0, 8'h00, 1'b0},
        {2'd0, 9'b110010000, 2'd1, 2'd2, 8'h04, 1'b0},
        {2'd0, 9'b110010100, 2'd0, 2'd0, 8'h00, 1'b0},
        {2'd0, 9'b110001110, 2'd1, 2'd2, 8'h04, 1'b0},
        {2'd0, 9'b000001100, 2'd0, 2'd0, 8'h00, 1'b0},
        {2'd1, 9'b110000010, 2'd1, 2'd2, 8'h04, 1'b0},
        {2'd1, 9'b110100010, 2'd0, 2'd0, 8'h00, 1'b1},
        {2'd1, 9'b000000010, 2'd0, 2'd0, 8'h00, 1'b0},
        {2'd2, 9'b110010011, 2'd0, 2'd0, 8'h00, 1'b1},
        {2'd3, 9'b110010011, 2'd0, 2'd0, 8'h00, 1'b1},
        {2'd3, 9'b000000011, 2'd0, 2'd0, 8'h00, 1'b0},
        {2'd0, 9'b100001110, 2'd0, 2'd0, 8'h00, 1'b1}
    };

    function automatic string tag_of(input int i);
        case (i)
            0:              return "R3";
            1, 2:           return "R5";
            3, 4, 5:        return "R6";
            6, 8, 16:       return "R7";
            7:              return "R10";
            9, 12:          return "R8";
            10, 11:         return "R4";
            default:        return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] lvl, input logic [8:0] c);
        priv_lvl       = lvl;
        hyp_present    = c[8];
        hyp_enabled    = c[7];
        lvl1_is32      = c[6];
        hyp_is32       = c[5];
        host_mode      = c[4];
        usr_cnt_en     = c[3];
        hyp_usr_cnt_en = c[2];
        lvl1_cnt_trap  = c[1];
        trap_general   = c[0];
    endtask

    initial begin
        #150000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0;
        set_cfg(2'd0, 9'b0);
        phys_count = '0; virt_offset = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0 && rsp_kind == 2'd0, "R1", "valid/kind in reset",
              {62'd0, rsp_kind}, 64'd0);
        check({rsp_hi, rsp_lo} == 64'd0 && rsp_target == 0 && rsp_syndrome == 0,
              "R1", "data in reset", {rsp_hi, rsp_lo}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1", "valid after release", {63'd0, rsp_valid}, 64'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] v;
            logic [63:0] exp_data;
            v = VEC[i];
            set_cfg(v[23:22], v[21:13]);
            phys_count  = 64'h1111_1111_0000_0001 * (i + 1) + 64'd5;
            virt_offset = 64'h8000_0000_0000_0003 + 64'(i);
            req_valid   = 1'b1;
            exp_data = (v[12:11] != 2'd0) ? 64'd0 :
                       (v[0] ? phys_count - virt_offset : phys_count);
            @(negedge clk);
            req_valid = 1'b0;
            check(rsp_valid == 1'b1, "R2", "valid one cycle after request",
                  {63'd0, rsp_valid}, 64'd1);
            check(rsp_kind == v[12:11], tag_of(i), "outcome kind",
                  {62'd0, rsp_kind}, {62'd0, v[12:11]});
            check(rsp_target == v[10:9], tag_of(i), "target level",
                  {62'd0, rsp_target}, {62'd0, v[10:9]});
            check(rsp_syndrome == v[8:1], tag_of(i), "syndrome",
                  {56'd0, rsp_syndrome}, {56'd0, v[8:1]});
            // R11 data zero on refusal, else value per R3/R8
            check({rsp_hi, rsp_lo} == exp_data, (v[12:11] != 0) ? "R11" : tag_of(i),
                  "data", {rsp_hi, rsp_lo}, exp_data);
        end

        // R2: pulse lasts one cycle
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2", "valid drops after idle", {63'd0, rsp_valid}, 64'd0);

        // R3: borrow from low word into high word at level 2
        set_cfg(2'd2, 9'b110000000);
        phys_count = 64'h0000_0001_0000_0000; virt_offset = 64'd1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_lo == 32'hFFFF_FFFF && rsp_hi == 32'd0, "R3", "borrow across halves",
              {rsp_hi, rsp_lo}, 64'h0000_0000_FFFF_FFFF);

        // R3: wrap below zero
        phys_count = 64'd2; virt_offset = 64'd5;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({rsp_hi, rsp_lo} == 64'hFFFF_FFFF_FFFF_FFFD, "R3", "modular wrap",
              {rsp_hi, rsp_lo}, 64'hFFFF_FFFF_FFFF_FFFD);

        // R2: back-to-back requests each carry their own sample
        set_cfg(2'd3, 9'b000000000);
        phys_count = 64'hAAAA_0000_0000_0001; virt_offset = 64'h10;
        req_valid = 1'b1;
        @(negedge clk);
        check({rsp_hi, rsp_lo} == 64'hAAAA_0000_0000_0001 && rsp_valid, "R2",
              "first back-to-back", {rsp_hi, rsp_lo}, 64'hAAAA_0000_0000_0001);
        phys_count = 64'hBBBB_0000_0000_0002;
        @(negedge clk);
        req_valid = 1'b0;
        check({rsp_hi, rsp_lo} == 64'hBBBB_0000_0000_0002 && rsp_valid, "R2",
              "second back-to-back", {rsp_hi, rsp_lo}, 64'hBBBB_0000_0000_0002);

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rsp_valid == 1'b0 && {rsp_hi, rsp_lo} == 64'd0, "R1", "reset clears",
              {rsp_hi, rsp_lo}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule